// File: doc/BRIEF.md
# Instruction-Stream Hazard Detector

This block watches a stream of already decoded instruction descriptors, at most one per clock when `in_valid` is high. It keeps pending state for seven pipeline hazards that the hardware does not resolve on its own. Each hazard has its own kinds of triggering instruction and its own set of instructions that cancel it. When an instruction would complete a hazard while it is still pending, the block raises that hazard's flag bit for one cycle. It also reports the index of the lowest flagged hazard.

A descriptor carries the following fields:

- a 4-bit instruction class;
- a wait kind and a wait immediate, for the wait class;
- a 128-bit mask of the scalar registers the instruction reads;
- one scalar register write target, with its enable;
- flags for reading and writing the execution mask;
- a scalar buffer address;
- the instruction's dword offset.

The execution mask is tracked as scalar register index 126 and the M0 register as index 124. Reading M0 is expressed through bit 124 of the read mask.

The block only observes the stream. A scheduler or an offline checker uses the flags to decide where waits or filler instructions are needed. Stalling, filler insertion and decoding are left to the surrounding logic.

Top module: `hazard_detector`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every pending hazard and zeroes `hz_flag`. An instruction that would complete a hazard whose trigger came before the reset is not flagged.
- R2: Bit 0 is set for a scalar-write-after-vector-memory-read hazard.
  - Trigger: a VMEM (class 11), FLAT (12) or DS (13) instruction reads scalar registers, through the read mask or the exec-read flag.
  - Completion: a later SALU (1), exempt SALU (3), SMEM (4) or scalar buffer load (6) writes one of those registers, through the write target or the exec-write flag.
- R3: The bit-0 hazard is cancelled by either of these:
  - any vector-ALU-family instruction (classes 7 VALU, 8 v_nop, 9 compare, 10 permlane);
  - a wait (class 15) of kind 1 (vector memory count) with immediate 0.
  Other instructions do not cancel it, including a kind-1 wait with a non-zero count, a kind-2 wait, SOPP (2), exempt SALU (3) and branch (14).
- R4: Bit 1 is set for a vector-write-after-scalar-memory-read hazard.
  - Trigger: an SMEM-family instruction (classes 4, 5, 6) reads scalar registers.
  - Completion: a later vector-ALU-family instruction writes one of them.
  - Cancelled by: a plain SALU (class 1), or a wait of kind 2 (scalar memory count) with any immediate.
  - Not cancelled by: exempt SALU (3), SOPP (2), or waits of other kinds.
- R5: Bit 2 is set when a permlane instruction (class 10) follows a compare (class 9). A VALU (7) or a permlane in between cancels the hazard; a v_nop (8) or a non-vector instruction does not.
- R6: Bit 3 is set for an execution-mask write-after-read hazard.
  - Trigger: an instruction outside the vector-ALU family reads the execution mask.
  - Completion: a later vector-ALU-family instruction writes the execution mask.
  - Cancelled by: a vector-ALU-family instruction with its scalar write enable set, or a wait of kind 4 (dependency counter) with immediate 0xFFFE.
  - Not cancelled by: a kind-4 wait with any other immediate.
- R7: Bit 4 is set for a memory access that crosses a branch.
  - Flagged sequences: a VMEM (class 11), then a branch (14), then a DS (13); or a DS, then a branch, then a VMEM.
  - Not flagged: the same pair without a branch, or a FLAT (12) in place of the VMEM.
  - Only a wait of kind 3 (vector store count) with immediate 0 cancels it.
- R8: Bit 5 is set when a scalar buffer load (class 6) uses the same address as one of the four most recent scalar buffer stores (class 5).
  - A fifth store replaces the oldest entry.
  - Only a wait of kind 2 with immediate 0 forgets the stores; a SOPP or a kind-2 wait with a non-zero count does not.
- R9: Bit 6 is set for a branch (class 14) whose dword offset has low six bits equal to 0x3F. Other branch offsets, and non-branch instructions at 0x3F, are not flagged.
- R10: Flag timing and identifier.
  - Flags appear on the rising edge after the offending instruction and last one cycle.
  - Cycles with `in_valid` low neither change state nor raise flags.
  - When several bits are set together, `hz_id` gives the lowest set bit index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Descriptor present this cycle |
| in_class | input | 4 | Instruction class code |
| in_wait_kind | input | 3 | Wait kind: 0 none, 1 vector memory, 2 scalar memory, 3 vector store, 4 dependency counter, 5 other |
| in_wait_imm | input | 16 | Wait immediate |
| in_sgpr_rd | input | 128 | Mask of scalar registers read |
| in_sgpr_wr_en | input | 1 | Instruction writes a scalar register |
| in_sgpr_wr_idx | input | 7 | Scalar register written |
| in_exec_rd | input | 1 | Instruction reads the execution mask |
| in_exec_wr | input | 1 | Instruction writes the execution mask |
| in_saddr | input | 32 | Scalar buffer address |
| in_offset | input | 16 | Instruction dword offset |
| hz_flag | output | 7 | Per-hazard flags, one-cycle pulse |
| hz_id | output | 3 | Index of the lowest set flag |

## Verification
Several hazards can be completed by one instruction in the same cycle. One case is an SMEM that reads the execution mask: it arms both the scalar-memory hazard and the execution-mask hazard. A following VALU that writes the execution mask then completes both at once. The bench provokes exactly this and expects bits 1 and 3 together with `hz_id` equal to 1. It also checks that the next idle cycle shows no flag at all, which proves the two hits pulse together and are neither merged nor held.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [3:0] {
    IC_OTHER     = 4'd0,
    IC_SALU      = 4'd1,
    IC_SOPP      = 4'd2,
    IC_SALU_XMPT = 4'd3,
    IC_SMEM      = 4'd4,
    IC_SBUF_ST   = 4'd5,
    IC_SBUF_LD   = 4'd6,
    IC_VALU      = 4'd7,
    IC_VNOP      = 4'd8,
    IC_VCMP      = 4'd9,
    IC_PERM      = 4'd10,
    IC_VMEM      = 4'd11,
    IC_FLAT      = 4'd12,
    IC_DS        = 4'd13,
    IC_BRANCH    = 4'd14,
    IC_WAIT      = 4'd15
  } iclass_e;

  typedef enum logic [2:0] {
    WK_NONE   = 3'd0,
    WK_VM     = 3'd1,
    WK_LGKM   = 3'd2,
    WK_VS     = 3'd3,
    WK_DEPCTR = 3'd4,
    WK_OTHER  = 3'd5
  } wkind_e;

  localparam int NUM_HAZ = 7;
  localparam int HZ_VMS  = 0;
  localparam int HZ_SMV  = 1;
  localparam int HZ_PERM = 2;
  localparam int HZ_EXEC = 3;
  localparam int HZ_LBV  = 4;
  localparam int HZ_SST  = 5;
  localparam int HZ_OFS  = 6;

  function automatic logic is_valu_f(input iclass_e c);
    return (c == IC_VALU) || (c == IC_VNOP) || (c == IC_VCMP) || (c == IC_PERM);
  endfunction

  function automatic logic is_scalar_writer_f(input iclass_e c);
    return (c == IC_SALU) || (c == IC_SALU_XMPT) || (c == IC_SMEM) || (c == IC_SBUF_LD);
  endfunction

  function automatic logic is_smem_f(input iclass_e c);
    return (c == IC_SMEM) || (c == IC_SBUF_ST) || (c == IC_SBUF_LD);
  endfunction

  function automatic logic [2:0] lowest_set_f(input logic [NUM_HAZ-1:0] f);
    logic [2:0] r;
    r = 3'd0;
    for (int i = NUM_HAZ - 1; i >= 0; i--) begin
      if (f[i]) r = 3'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/hz_mask_track.sv
module hz_mask_track #(
  parameter int N = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic [N-1:0] set_mask,
  input  logic         chk_en,
  input  logic [N-1:0] chk_mask,
  input  logic         clr,
  output logic         hit
);

  logic [N-1:0] pend;

  assign hit = chk_en && ((pend & chk_mask) != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else if (clr) begin
      pend <= '0;
    end else if (set_en) begin
      pend <= pend | set_mask;
    end
  end

  // R3
  clr_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pend == '0));

  // R2
  set_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (set_en && !clr) |=> ((pend & $past(set_mask)) == $past(set_mask)));

endmodule

// File: rtl/hz_branch_seq.sv
module hz_branch_seq (
  input  logic clk,
  input  logic rst,
  input  logic vm_ev,
  input  logic ds_ev,
  input  logic br_ev,
  input  logic clr,
  output logic hit
);

  logic vm_seen, ds_seen, vm_br, ds_br;

  assign hit = (vm_ev && ds_br) || (ds_ev && vm_br);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vm_seen <= 1'b0;
      ds_seen <= 1'b0;
      vm_br   <= 1'b0;
      ds_br   <= 1'b0;
    end else begin
      if (vm_ev) vm_seen <= 1'b1;
      if (ds_ev) ds_seen <= 1'b1;
      if (br_ev) begin
        vm_br <= vm_br | vm_seen;
        ds_br <= ds_br | ds_seen;
      end
    end
  end

  // R7
  vscnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !(vm_br || ds_br || vm_seen || ds_seen));

  // R7
  needs_branch_chk: assert property (@(posedge clk) disable iff (rst)
    (!br_ev && !vm_br && !ds_br) |=> !(vm_br || ds_br));

endmodule

// File: rtl/hz_store_match.sv
module hz_store_match #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_en,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              clr,
  output logic              hit
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [DEPTH-1:0]  ent_vld;
  logic [DEPTH-1:0]  match;
  logic [PTR_W-1:0]  wr_ptr;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = ent_vld[g] && (ent_addr[g] == addr);
  end

  assign hit = ld_en && (match != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld <= '0;
      wr_ptr  <= '0;
    end else if (clr) begin
      ent_vld <= '0;
    end else if (st_en) begin
      ent_addr[wr_ptr] <= addr;
      ent_vld[wr_ptr]  <= 1'b1;
      wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    end
  end

  // R8
  lgkm_forget_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (ent_vld == '0));

  // R8
  store_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (st_en && !clr) |=> ($countones(ent_vld) >= 1));

endmodule

// File: rtl/hazard_detector.sv
module hazard_detector
  import hz_pkg::*;
#(
  parameter int SGPR_N   = 128,
  parameter int IMM_W    = 16,
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 16,
  parameter int ST_DEPTH = 4,
  parameter int EXEC_IDX = 126,
  parameter int M0_IDX   = 124,
  parameter logic [IMM_W-1:0] DEPCTR_KEY = 16'hFFFE,
  localparam int IDX_W   = $clog2(SGPR_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        in_class,
  input  logic [2:0]        in_wait_kind,
  input  logic [IMM_W-1:0]  in_wait_imm,
  input  logic [SGPR_N-1:0] in_sgpr_rd,
  input  logic              in_sgpr_wr_en,
  input  logic [IDX_W-1:0]  in_sgpr_wr_idx,
  input  logic              in_exec_rd,
  input  logic              in_exec_wr,
  input  logic [ADDR_W-1:0] in_saddr,
  input  logic [OFF_W-1:0]  in_offset,
  output logic [NUM_HAZ-1:0] hz_flag,
  output logic [2:0]        hz_id
);

  localparam logic [SGPR_N-1:0] ONE_BIT  = SGPR_N'(1);
  localparam logic [SGPR_N-1:0] EXEC_BIT = ONE_BIT << EXEC_IDX;
  localparam logic [OFF_W-1:0]  OFS_MASK = OFF_W'(63);

  iclass_e cls;
  wkind_e  wk;
  logic    v, valu, is_wait, imm_zero;
  logic [SGPR_N-1:0] rd_mask, wr_mask;

  // named events
  logic ev_vmem_rd, ev_scalar_wr, ev_vms_clr;
  logic ev_smem_rd, ev_valu_wr, ev_smv_clr;
  logic ev_vm, ev_ds, ev_br, ev_vs0;
  logic ev_st, ev_ld, ev_lgkm0;
  logic ev_exec_rd_nv, ev_exec_wr_v, ev_exec_clr;

  logic hit_vms, hit_smv, hit_perm, hit_exec, hit_lbv, hit_sst, hit_ofs;
  logic perm_pend, exec_pend;
  logic [NUM_HAZ-1:0] hits;

  assign cls      = iclass_e'(in_class);
  assign wk       = wkind_e'(in_wait_kind);
  assign v        = in_valid;
  assign valu     = is_valu_f(cls);
  assign is_wait  = (cls == IC_WAIT);
  assign imm_zero = (in_wait_imm == '0);

  assign rd_mask = in_sgpr_rd | (in_exec_rd ? EXEC_BIT : '0);
  assign wr_mask = (in_sgpr_wr_en ? (ONE_BIT << in_sgpr_wr_idx) : '0)
                 | (in_exec_wr ? EXEC_BIT : '0);

  assign ev_vmem_rd   = v && ((cls == IC_VMEM) || (cls == IC_FLAT) || (cls == IC_DS));
  assign ev_scalar_wr = v && is_scalar_writer_f(cls);
  assign ev_vms_clr   = v && (valu || (is_wait && wk == WK_VM && imm_zero));

  assign ev_smem_rd   = v && is_smem_f(cls);
  assign ev_valu_wr   = v && valu;
  assign ev_smv_clr   = v && ((cls == IC_SALU) || (is_wait && wk == WK_LGKM));

  assign ev_vm    = v && (cls == IC_VMEM);
  assign ev_ds    = v && (cls == IC_DS);
  assign ev_br    = v && (cls == IC_BRANCH);
  assign ev_vs0   = v && is_wait && (wk == WK_VS) && imm_zero;

  assign ev_st    = v && (cls == IC_SBUF_ST);
  assign ev_ld    = v && (cls == IC_SBUF_LD);
  assign ev_lgkm0 = v && is_wait && (wk == WK_LGKM) && imm_zero;

  assign ev_exec_rd_nv = v && !valu && in_exec_rd;
  assign ev_exec_wr_v  = v && valu && in_exec_wr;
  assign ev_exec_clr   = v && ((valu && in_sgpr_wr_en) ||
                               (is_wait && wk == WK_DEPCTR && in_wait_imm == DEPCTR_KEY));

  hz_mask_track #(.N(SGPR_N)) u_vms (
    .clk(clk), .rst(rst),
    .set_en(ev_vmem_rd), .set_mask(rd_mask),
    .chk_en(ev_scalar_wr), .chk_mask(wr_mask),
    .clr(ev_vms_clr), .hit(hit_vms)
  );

  hz_mask_track #(.N(SGPR_N)) u_smv (
    .clk(clk), .rst(rst),
    .set_en(ev_smem_rd), .set_mask(rd_mask),
    .chk_en(ev_valu_wr), .chk_mask(wr_mask),
    .clr(ev_smv_clr), .hit(hit_smv)
  );

  hz_branch_seq u_lbv (
    .clk(clk), .rst(rst),
    .vm_ev(ev_vm), .ds_ev(ev_ds), .br_ev(ev_br),
    .clr(ev_vs0), .hit(hit_lbv)
  );

  hz_store_match #(.ADDR_W(ADDR_W), .DEPTH(ST_DEPTH)) u_sst (
    .clk(clk), .rst(rst),
    .st_en(ev_st), .ld_en(ev_ld), .addr(in_saddr),
    .clr(ev_lgkm0), .hit(hit_sst)
  );

  assign hit_perm = v && (cls == IC_PERM) && perm_pend;
  assign hit_exec = ev_exec_wr_v && exec_pend;
  assign hit_ofs  = ev_br && ((in_offset & OFS_MASK) == OFS_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      perm_pend <= 1'b0;
      exec_pend <= 1'b0;
    end else if (v) begin
      if (cls == IC_VCMP) perm_pend <= 1'b1;
      else if (cls == IC_VALU || cls == IC_PERM) perm_pend <= 1'b0;
      if (ev_exec_clr) exec_pend <= 1'b0;
      else if (ev_exec_rd_nv) exec_pend <= 1'b1;
    end
  end

  always_comb begin
    hits = '0;
    hits[HZ_VMS]  = hit_vms;
    hits[HZ_SMV]  = hit_smv;
    hits[HZ_PERM] = hit_perm;
    hits[HZ_EXEC] = hit_exec;
    hits[HZ_LBV]  = hit_lbv;
    hits[HZ_SST]  = hit_sst;
    hits[HZ_OFS]  = hit_ofs;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hz_flag <= '0;
      hz_id   <= '0;
    end else begin
      hz_flag <= v ? hits : '0;
      hz_id   <= v ? lowest_set_f(hits) : '0;
    end
  end

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> (hz_flag == '0));

  // R10
  id_match_chk: assert property (@(posedge clk) disable iff (rst)
    (hz_flag != '0) |-> hz_flag[hz_id]);

  // R9
  br_offset_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cls == IC_BRANCH && in_offset[5:0] == 6'h3F) |=> hz_flag[HZ_OFS]);

  // R5
  perm_source_chk: assert property (@(posedge clk) disable iff (rst)
    hz_flag[HZ_PERM] |-> ($past(in_class) == 4'(IC_PERM)));

  // R6
  exec_source_chk: assert property (@(posedge clk) disable iff (rst)
    hz_flag[HZ_EXEC] |-> $past(in_exec_wr));

endmodule

// File: tb/hazard_detector_tb.sv
module hazard_detector_tb;
  import hz_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [3:0]   in_class;
  logic [2:0]   in_wait_kind;
  logic [15:0]  in_wait_imm;
  logic [127:0] in_sgpr_rd;
  logic         in_sgpr_wr_en;
  logic [6:0]   in_sgpr_wr_idx;
  logic         in_exec_rd;
  logic         in_exec_wr;
  logic [31:0]  in_saddr;
  logic [15:0]  in_offset;
  logic [6:0]   hz_flag;
  logic [2:0]   hz_id;

  int n_cmp  = 0;
  int n_bad  = 0;
  int cycles = 0;
  bit done   = 0;

  hazard_detector u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
    .in_wait_kind(in_wait_kind), .in_wait_imm(in_wait_imm),
    .in_sgpr_rd(in_sgpr_rd), .in_sgpr_wr_en(in_sgpr_wr_en),
    .in_sgpr_wr_idx(in_sgpr_wr_idx), .in_exec_rd(in_exec_rd),
    .in_exec_wr(in_exec_wr), .in_saddr(in_saddr), .in_offset(in_offset),
    .hz_flag(hz_flag), .hz_id(hz_id)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  // Drive at a falling edge; after it the next falling edge shows the registered result.
  task automatic put(input bit vld, input logic [3:0] c, input logic [2:0] k,
                     input logic [15:0] imm, input logic [127:0] rd,
                     input bit we, input logic [6:0] wi, input bit er, input bit ew,
                     input logic [31:0] a, input logic [15:0] off);
    in_valid = vld; in_class = c; in_wait_kind = k; in_wait_imm = imm;
    in_sgpr_rd = rd; in_sgpr_wr_en = we; in_sgpr_wr_idx = wi;
    in_exec_rd = er; in_exec_wr = ew; in_saddr = a; in_offset = off;
    @(negedge clk);
  endtask

  task automatic op(input iclass_e c);
    put(1, 4'(c), 3'd0, 16'd0, '0, 0, 7'd0, 0, 0, 32'd0, 16'd0);
  endtask

  task automatic rd_op(input iclass_e c, input int idx);
    put(1, 4'(c), 3'd0, 16'd0, 128'd1 << idx, 0, 7'd0, 0, 0, 32'd0, 16'd0);
  endtask

  task automatic wr_op(input iclass_e c, input int idx);
    put(1, 4'(c), 3'd0, 16'd0, '0, 1, 7'(idx), 0, 0, 32'd0, 16'd0);
  endtask

  task automatic wt(input wkind_e k, input logic [15:0] imm);
    put(1, 4'(IC_WAIT), 3'(k), imm, '0, 0, 7'd0, 0, 0, 32'd0, 16'd0);
  endtask

  task automatic mem(input iclass_e c, input logic [31:0] a);
    put(1, 4'(c), 3'd0, 16'd0, '0, 0, 7'd0, 0, 0, a, 16'd0);
  endtask

  task automatic idle();
    put(0, 4'd0, 3'd0, 16'd0, '0, 0, 7'd0, 0, 0, 32'd0, 16'd0);
  endtask

  task automatic chk(input string req, input logic [6:0] exp);
    logic [2:0] eid;
    eid = 3'd0;
    for (int i = 6; i >= 0; i--) if (exp[i]) eid = 3'(i);
    n_cmp++;
    if (hz_flag !== exp || (exp != 0 && hz_id !== eid)) begin
      n_bad++;
      $display("FAIL %s: flags=%b id=%0d expected flags=%b id=%0d",
               req, hz_flag, hz_id, exp, eid);
    end
  endtask

  // Flush every pending hazard; none of these instructions completes one.
  task automatic clean();
    op(IC_VALU); op(IC_SALU);
    wt(WK_VS, 16'd0); wt(WK_LGKM, 16'd0); wt(WK_DEPCTR, 16'hFFFE);
  endtask

  iclass_e rdr [3] = '{IC_VMEM, IC_FLAT, IC_DS};
  iclass_e wrr [4] = '{IC_SALU, IC_SALU_XMPT, IC_SMEM, IC_SBUF_LD};

  initial begin
    rst = 1'b1;
    put(0, 4'd0, 3'd0, 16'd0, '0, 0, 7'd0, 0, 0, 32'd0, 16'd0);
    @(negedge clk);
    // R1: reset state
    chk("R1 reset flags", 7'd0);
    rst = 1'b0;
    rd_op(IC_VMEM, 5);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    wr_op(IC_SALU, 5);
    chk("R1 pending cleared by reset", 7'd0);
    clean();

    // R2: sweep every scalar register index
    for (int i = 0; i < 128; i++) begin
      rd_op(rdr[i % 3], i);
      wr_op(wrr[i % 4], (i + 1) % 128);
      chk("R2 other register", 7'd0);
      wr_op(wrr[(i + 1) % 4], i);
      chk("R2 same register", 7'b0000001);
      clean();
    end
    put(1, 4'(IC_VMEM), 3'd0, 16'd0, '0, 0, 7'd0, 1, 0, 32'd0, 16'd0);
    put(1, 4'(IC_SALU), 3'd0, 16'd0, '0, 0, 7'd0, 0, 1, 32'd0, 16'd0);
    chk("R2 exec as register", 7'b0000001);
    clean();

    // R3: mitigators and non-mitigators
    for (int m = 0; m < 10; m++) begin
      rd_op(IC_VMEM, 10);
      case (m)
        0: op(IC_VALU);
        1: op(IC_VNOP);
        2: op(IC_VCMP);
        3: op(IC_PERM);
        4: wt(WK_VM, 16'd0);
        5: op(IC_SOPP);
        6: wt(WK_VM, 16'd1);
        7: wt(WK_LGKM, 16'd0);
        8: op(IC_SALU_XMPT);
        default: op(IC_BRANCH);
      endcase
      wr_op(IC_SALU, 10);
      chk("R3 mitigation", (m < 5) ? 7'd0 : 7'b0000001);
      clean();
    end

    // R4: sweep indices, then mitigators
    for (int i = 0; i < 128; i++) begin
      rd_op(IC_SMEM, i);
      wr_op(IC_VALU, (i + 3) % 128);
      chk("R4 other register", 7'd0);
      wr_op(IC_VALU, i);
      chk("R4 same register", 7'b0000010);
      clean();
    end
    for (int m = 0; m < 6; m++) begin
      rd_op(IC_SBUF_ST, 20);
      case (m)
        0: op(IC_SALU);
        1: wt(WK_LGKM, 16'd5);
        2: op(IC_SALU_XMPT);
        3: wt(WK_VM, 16'd0);
        4: wt(WK_OTHER, 16'd0);
        default: op(IC_SOPP);
      endcase
      wr_op(IC_VALU, 20);
      chk("R4 mitigation", (m < 2) ? 7'd0 : 7'b0000010);
      clean();
    end

    // R5: compare then permlane
    op(IC_VCMP); op(IC_PERM);
    chk("R5 direct", 7'b0000100);
    op(IC_PERM);
    chk("R5 cleared by permlane", 7'd0);
    op(IC_VCMP); op(IC_VALU); op(IC_PERM);
    chk("R5 valu mitigates", 7'd0);
    op(IC_VCMP); op(IC_VNOP); op(IC_PERM);
    chk("R5 v_nop does not", 7'b0000100);
    op(IC_VCMP); op(IC_SALU); op(IC_PERM);
    chk("R5 salu does not", 7'b0000100);
    clean();

    // R6: exec write after read
    put(1, 4'(IC_SALU), 3'd0, 16'd0, '0, 0, 7'd0, 1, 0, 32'd0, 16'd0);
    put(1, 4'(IC_VALU), 3'd0, 16'd0, '0, 0, 7'd0, 0, 1, 32'd0, 16'd0);
    chk("R6 direct", 7'b0001000);
    clean();
    put(1, 4'(IC_SALU), 3'd0, 16'd0, '0, 0, 7'd0, 1, 0, 32'd0, 16'd0);
    wr_op(IC_VALU, 7);
    put(1, 4'(IC_VALU), 3'd0, 16'd0, '0, 0, 7'd0, 0, 1, 32'd0, 16'd0);
    chk("R6 valu sgpr write mitigates", 7'd0);
    clean();
    put(1, 4'(IC_SALU), 3'd0, 16'd0, '0, 0, 7'd0, 1, 0, 32'd0, 16'd0);
    wt(WK_DEPCTR, 16'hFFFE);
    put(1, 4'(IC_VALU), 3'd0, 16'd0, '0, 0, 7'd0, 0, 1, 32'd0, 16'd0);
    chk("R6 depctr key mitigates", 7'd0);
    put(1, 4'(IC_SALU), 3'd0, 16'd0, '0, 0, 7'd0, 1, 0, 32'd0, 16'd0);
    wt(WK_DEPCTR, 16'hFFFF);
    put(1, 4'(IC_VALU), 3'd0, 16'd0, '0, 0, 7'd0, 0, 1, 32'd0, 16'd0);
    chk("R6 other depctr does not", 7'b0001000);
    clean();
    put(1, 4'(IC_VALU), 3'd0, 16'd0, '0, 0, 7'd0, 1, 0, 32'd0, 16'd0);
    put(1, 4'(IC_VALU), 3'd0, 16'd0, '0, 0, 7'd0, 0, 1, 32'd0, 16'd0);
    chk("R6 valu read does not arm", 7'd0);
    clean();

    // R7: memory across a branch
    op(IC_VMEM); op(IC_BRANCH); op(IC_DS);
    chk("R7 vmem branch ds", 7'b0010000);
    clean();
    op(IC_DS); op(IC_BRANCH); op(IC_VMEM);
    chk("R7 ds branch vmem", 7'b0010000);
    clean();
    op(IC_VMEM); op(IC_DS);
    chk("R7 no branch", 7'd0);
    clean();
    op(IC_FLAT); op(IC_BRANCH); op(IC_DS);
    chk("R7 flat excluded", 7'd0);
    clean();
    op(IC_VMEM); op(IC_BRANCH); wt(WK_VS, 16'd0); op(IC_DS);
    chk("R7 vscnt0 mitigates", 7'd0);
    clean();
    op(IC_VMEM); op(IC_BRANCH); wt(WK_VS, 16'd1); op(IC_DS);
    chk("R7 vscnt1 does not", 7'b0010000);
    clean();

    // R8: store then load, address sweep
    for (int i = 0; i < 16; i++) begin
      logic [31:0] a;
      a = 32'h1000 + 32'(i) * 32'h44;
      mem(IC_SBUF_ST, a);
      mem(IC_SBUF_LD, a + 32'd4);
      chk("R8 other address", 7'd0);
      op(IC_SOPP);
      mem(IC_SBUF_LD, a);
      chk("R8 same address", 7'b0100000);
      wt(WK_LGKM, 16'd1);
      mem(IC_SBUF_LD, a);
      chk("R8 lgkm1 keeps", 7'b0100000);
      wt(WK_LGKM, 16'd0);
      mem(IC_SBUF_LD, a);
      chk("R8 lgkm0 forgets", 7'd0);
      clean();
    end
    for (int s = 0; s < 5; s++) mem(IC_SBUF_ST, 32'h200 + 32'(s));
    mem(IC_SBUF_LD, 32'h200);
    chk("R8 oldest evicted", 7'd0);
    for (int s = 1; s < 5; s++) begin
      mem(IC_SBUF_LD, 32'h200 + 32'(s));
      chk("R8 recent kept", 7'b0100000);
    end
    clean();

    // R9: offset sweep
    for (int o = 0; o < 256; o++) begin
      put(1, 4'(IC_BRANCH), 3'd0, 16'd0, '0, 0, 7'd0, 0, 0, 32'd0, 16'(o));
      chk("R9 branch offset", ((o % 64) == 63) ? 7'b1000000 : 7'd0);
    end
    put(1, 4'(IC_SOPP), 3'd0, 16'd0, '0, 0, 7'd0, 0, 0, 32'd0, 16'h3F);
    chk("R9 non-branch at 0x3F", 7'd0);
    clean();

    // R10: invalid cycles ignored, pulse width, simultaneous hits
    put(0, 4'(IC_VMEM), 3'd0, 16'd0, 128'd1 << 3, 0, 7'd0, 0, 0, 32'd0, 16'd0);
    chk("R10 invalid no flag", 7'd0);
    wr_op(IC_SALU, 3);
    chk("R10 invalid not armed", 7'd0);
    clean();
    put(1, 4'(IC_SMEM), 3'd0, 16'd0, '0, 0, 7'd0, 1, 0, 32'd0, 16'd0);
    put(1, 4'(IC_VALU), 3'd0, 16'd0, '0, 0, 7'd0, 0, 1, 32'd0, 16'd0);
    chk("R10 two hazards at once", 7'b0001010);
    idle();
    chk("R10 one-cycle pulse", 7'd0);
    clean();

    finish_run();
  end

endmodule